// File: doc/BRIEF.md
# CPU program bank mapper

This block places a large program ROM behind the console CPU's upper 32 KB of address space. Two bank registers, written through the cartridge register window, steer two switchable regions. The region at 0x8000-0xBFFF shows any whole 16 KB bank. The region at 0xC000-0xDFFF shows an 8 KB window that can only be the lower half of a chosen 16 KB bank. The top 8 KB at 0xE000-0xFFFF is fixed to the upper half of the last 16 KB bank, so the reset and interrupt vectors are always present.

The block outputs ROM address bits 18:13 (the CPU drives bits 12:0 straight to the ROM) and a ROM chip-enable. The register that holds the first bank number also holds a 2-bit video-mode field. That field is stored and brought out unchanged for other logic to use. Register writes take effect at the rising clock edge of the write cycle. The mapping outputs are combinational from the stored state and the current CPU address.

Top module: `prg_bank_mapper`

## Requirements
- R1: After a synchronous reset, both bank numbers and the video-mode field read as zero. A read at 0x8000 then gives rom_addr_hi = 0 and video_mode = 0.
- R2: A register write reaches the mapper only when cpu_addr[15] = 0, cpu_addr[13] = 0, cpu_addr[12] = 1 and cpu_addr[11] = 1 (0x5800-0x5FFF or 0x1800-0x1FFF). Bits 14 and 10:4 are don't-care. Writes to any other address change nothing.
- R3: Within that window, cpu_addr[3:0] = 0x1 selects the first bank register and 0x2 selects the second. Every other index value leaves both registers and video_mode unchanged.
- R4: A write to index 0x1 stores cpu_data[4:0] as the first bank number and cpu_data[7:6] as video_mode. cpu_data[5] is ignored.
- R5: A write to index 0x2 stores cpu_data[4:0] as the second bank number. cpu_data[7:5] are ignored.
- R6: State changes only on a clock edge where cpu_strobe = 1 and cpu_rnw = 0. Reads, and cycles with the strobe low, leave all state unchanged.
- R7: For cpu_addr[15:14] = 2'b10, rom_addr_hi = {first bank, cpu_addr[13]}.
- R8: For cpu_addr[15:13] = 3'b110, rom_addr_hi = {second bank, 1'b0}.
- R9: For cpu_addr[15:13] = 3'b111, rom_addr_hi = 6'h3F, whatever the registers hold.
- R10: For cpu_addr[15] = 0, rom_addr_hi = 0.
- R11: rom_ce = 1 exactly when cpu_strobe = 1, cpu_rnw = 1 and cpu_addr[15] = 1. Writes never enable the ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_strobe | input | 1 | High during a valid CPU bus cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| rom_addr_hi | output | 6 | Program ROM address bits 18:13 |
| rom_ce | output | 1 | Program ROM chip-enable, active high |
| video_mode | output | 2 | Stored video-mode field |

## Verification
The assertions check on every cycle the address rules that do not depend on stored state:
- the zero output below 0x8000;
- the all-ones fixed top window;
- the forced-low bit 13 in the 8 KB window;
- the chip-enable rule;
- that the bank registers hold steady when no write strobe is present.

Only the bench's scenarios can show the following:
- that a decoded write lands in the right register, with the right bit slices;
- that near-miss addresses and unused indices are rejected;
- that the values read back through the two switchable windows match the bank numbers that were written.

// File: rtl/prgm_pkg.sv
package prgm_pkg;

    localparam int BANK_W   = 5;
    localparam int VMODE_W  = 2;
    localparam int HI_W     = BANK_W + 1;
    localparam int IDX_W    = 4;

    localparam logic [IDX_W-1:0] IDX_BANK_A = 4'h1;
    localparam logic [IDX_W-1:0] IDX_BANK_B = 4'h2;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_SWITCH = 2'd1,
        WIN_LOW8   = 2'd2,
        WIN_FIXED  = 2'd3
    } window_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_A    = 2'd1,
        SEL_B    = 2'd2
    } regsel_e;

    typedef struct packed {
        logic [VMODE_W-1:0] vmode;
        logic [BANK_W-1:0]  bank_a;
        logic [BANK_W-1:0]  bank_b;
    } cfg_t;

    // Region class from the top three CPU address bits
    function automatic window_e classify(input logic [2:0] top3);
        window_e w;
        if (!top3[2])
            w = WIN_NONE;
        else if (!top3[1])
            w = WIN_SWITCH;
        else if (!top3[0])
            w = WIN_LOW8;
        else
            w = WIN_FIXED;
        return w;
    endfunction

    // Register window match: A15=0, A13=0, A12=1, A11=1
    function automatic logic in_reg_space(input logic a15, input logic a13,
                                          input logic a12, input logic a11);
        return (!a15) && (!a13) && a12 && a11;
    endfunction

endpackage

// File: rtl/prgm_decode.sv
module prgm_decode
    import prgm_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_strobe,
    input  logic        cpu_rnw,
    output regsel_e     wsel
);
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic              unused_addr_bits;

    assign unused_addr_bits = &{1'b0, cpu_addr[14], cpu_addr[10:4]};
    assign idx = cpu_addr[IDX_W-1:0];
    assign hit = cpu_strobe && !cpu_rnw &&
                 in_reg_space(cpu_addr[15], cpu_addr[13], cpu_addr[12], cpu_addr[11]);

    always_comb begin
        wsel = SEL_NONE;
        if (hit) begin
            if (idx == IDX_BANK_A)
                wsel = SEL_A;
            else if (idx == IDX_BANK_B)
                wsel = SEL_B;
        end
    end

endmodule

// File: rtl/prgm_regs.sv
module prgm_regs
    import prgm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  regsel_e     wsel,
    input  logic [7:0]  wdata,
    input  logic        cpu_strobe,
    input  logic        cpu_rnw,
    output cfg_t        cfg
);
    cfg_t cfg_q;
    logic unused_data_bit;

    assign unused_data_bit = &{1'b0, wdata[5]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            case (wsel)
                SEL_A: begin
                    cfg_q.bank_a <= wdata[BANK_W-1:0];
                    cfg_q.vmode  <= wdata[7:6];
                end
                SEL_B: cfg_q.bank_b <= wdata[BANK_W-1:0];
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(cpu_strobe && !cpu_rnw) |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/prgm_xlate.sv
module prgm_xlate
    import prgm_pkg::*;
(
    input  logic [2:0]       top3,
    input  cfg_t             cfg,
    output logic [HI_W-1:0]  rom_addr_hi
);
    window_e win;

    assign win = classify(top3);

    always_comb begin
        case (win)
            WIN_SWITCH: rom_addr_hi = {cfg.bank_a, top3[0]};
            WIN_LOW8:   rom_addr_hi = {cfg.bank_b, 1'b0};
            WIN_FIXED:  rom_addr_hi = '1;
            default:    rom_addr_hi = '0;
        endcase
    end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_data,
    input  logic             cpu_strobe,
    input  logic             cpu_rnw,
    output logic [HI_W-1:0]  rom_addr_hi,
    output logic             rom_ce,
    output logic [VMODE_W-1:0] video_mode
);
    regsel_e wsel;
    cfg_t    cfg;

    prgm_decode u_dec (
        .cpu_addr   (cpu_addr),
        .cpu_strobe (cpu_strobe),
        .cpu_rnw    (cpu_rnw),
        .wsel       (wsel)
    );

    prgm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wsel       (wsel),
        .wdata      (cpu_data),
        .cpu_strobe (cpu_strobe),
        .cpu_rnw    (cpu_rnw),
        .cfg        (cfg)
    );

    prgm_xlate u_xl (
        .top3        (cpu_addr[15:13]),
        .cfg         (cfg),
        .rom_addr_hi (rom_addr_hi)
    );

    assign rom_ce     = cpu_strobe && cpu_rnw && cpu_addr[15];
    assign video_mode = cfg.vmode;

    AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[15] |-> rom_addr_hi == '0); // R10
    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15:13] == 3'b111 |-> rom_addr_hi == '1); // R9
    AST_LOW8_BIT13: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15:13] == 3'b110 |-> !rom_addr_hi[0]); // R8
    AST_NO_CE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !cpu_rnw |-> !rom_ce); // R11

endmodule

// File: tb/sim_prg_bank_mapper.sv
module sim_prg_bank_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_strobe = 1'b0;
    logic        cpu_rnw = 1'b1;
    logic [5:0]  rom_addr_hi;
    logic        rom_ce;
    logic [1:0]  video_mode;

    int checks = 0;
    int errors = 0;
    logic [4:0] mb_a = '0;
    logic [4:0] mb_b = '0;
    logic [1:0] mvm  = '0;
    int unsigned seed_dummy;

    always #4 clk = ~clk;

    prg_bank_mapper u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_strobe(cpu_strobe), .cpu_rnw(cpu_rnw),
        .rom_addr_hi(rom_addr_hi), .rom_ce(rom_ce), .video_mode(video_mode)
    );

    function automatic logic [5:0] exp_hi(input logic [15:0] a,
                                          input logic [4:0] ba, input logic [4:0] bb);
        if (!a[15])          return 6'h00;
        if (!a[14])          return {ba, a[13]};
        if (!a[13])          return {bb, 1'b0};
        return 6'h3F;
    endfunction

    function automatic logic reg_hit(input logic [15:0] a);
        return !a[15] && !a[13] && a[12] && a[11];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle; model updated per R2..R6
    task automatic bus(input logic [15:0] a, input logic [7:0] d,
                       input logic stb, input logic rnw);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_strobe = stb; cpu_rnw = rnw;
        @(posedge clk);
        if (stb && !rnw && reg_hit(a)) begin
            if (a[3:0] == 4'h1) begin mb_a = d[4:0]; mvm = d[7:6]; end
            else if (a[3:0] == 4'h2) mb_b = d[4:0];
        end
    endtask

    // Read probe: check mapping and chip-enable between edges
    task automatic probe(input string req, input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rnw = 1'b1; cpu_strobe = 1'b1;
        #1;
        chk(req, {2'b00, rom_addr_hi}, {2'b00, exp_hi(a, mb_a, mb_b)});
        chk("R11", {7'b0, rom_ce}, {7'b0, a[15]});
        chk("R4", {6'b0, video_mode}, {6'b0, mvm});
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        probe("R1", 16'h8000);
        probe("R1", 16'hA000);
        // R4, R7 directed
        bus(16'h5801, 8'hFF, 1'b1, 1'b0);
        probe("R4", 16'h8000);
        probe("R7", 16'hB123);
        // R5, R8
        bus(16'h1802, 8'hF3, 1'b1, 1'b0);
        probe("R5", 16'hC000);
        probe("R8", 16'hDFFF);
        // R9 fixed window
        probe("R9", 16'hE000);
        probe("R9", 16'hFFFC);
        // R10 lower half
        probe("R10", 16'h5801);
        // R2 near misses: A13 set, A15 set, A12 clear
        bus(16'h7801, 8'h05, 1'b1, 1'b0);
        bus(16'hD802, 8'h05, 1'b1, 1'b0);
        bus(16'h4801, 8'h05, 1'b1, 1'b0);
        probe("R2", 16'h8000);
        probe("R2", 16'hC000);
        // R3 other indices
        bus(16'h5803, 8'h00, 1'b1, 1'b0);
        bus(16'h5FF0, 8'h00, 1'b1, 1'b0);
        probe("R3", 16'h9000);
        // R6 read and idle cycles
        bus(16'h5801, 8'h00, 1'b1, 1'b1);
        bus(16'h5802, 8'h00, 1'b0, 1'b0);
        probe("R6", 16'h8000);
        probe("R6", 16'hC000);
        // R11 writes in ROM space do not enable ROM
        @(negedge clk);
        cpu_addr = 16'h9000; cpu_rnw = 1'b0; cpu_strobe = 1'b1; #1;
        chk("R11", {7'b0, rom_ce}, 8'h00);
        cpu_strobe = 1'b0; cpu_rnw = 1'b1; #1;
        chk("R11", {7'b0, rom_ce}, 8'h00);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom_range(1, 0) == 1)
                a = {1'b0, a[14], 1'b0, 2'b11, a[10:4], 2'b00, 2'($urandom_range(2, 1))};
            bus(a, 8'($urandom), ($urandom_range(9, 0) != 0), ($urandom_range(3, 0) == 0));
            probe("R7", {2'b10, 14'($urandom)});
            probe("R8", {3'b110, 13'($urandom)});
        end
        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        mb_a = '0; mb_b = '0; mvm = '0;
        probe("R1", 16'hC000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule